// File: doc/BRIEF.md
# UART Receive Framer

This block turns an asynchronous serial line into characters. A one-cycle sample enable, running at sixteen times the bit rate, paces the receiver. A low level seen on the line starts a frame. The receiver checks that level again half a bit later, then takes each later bit at the middle of its bit period. The character is 5 to 8 bits long, sent least significant bit first. After the data comes an optional parity-position bit and then one stop bit. Each finished character is written into an 8-entry FIFO together with three flags: a parity-error flag, a framing-error flag and an address flag.

An 8-bit mode word sets everything. It chooses the character length and how the parity-position bit is used: it is checked against even or odd parity, compared with a fixed level, left out entirely, or kept as an address/data marker on a shared multi-drop line. The mode word also chooses how errors are shown. In per-character mode the flags belong to the character at the head of the FIFO. In block mode the flags accumulate and hold until a command clears them. Finally, the mode word picks whether the interrupt request follows "FIFO not empty" or "FIFO full". Software pulls characters out of the FIFO with a pop strobe.

Top module: `uart_rx_framer`

## Requirements
- R1: After reset the FIFO is empty: `rx_avail`, `rx_full`, `rx_irq`, `st_parity`, `st_frame`, `st_overrun` and `st_addr` are all 0, and `rx_data` reads 0.
- R2: `mode_cfg[1:0]` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives least significant bit first and is shown right-aligned on `rx_data`, with the unused upper bits at 0.
- R3: With `mode_cfg[4:3]` = 0, the bit after the data is checked as a parity bit. `mode_cfg[2]` = 0 means even parity and 1 means odd parity. A mismatch sets the character's parity-error flag.
- R4: With `mode_cfg[4:3]` = 1, the bit after the data must equal `mode_cfg[2]`. Any other value sets the parity-error flag.
- R5: With `mode_cfg[4:3]` = 2, no parity bit is sent: the stop bit follows the data directly. Such a character never has its parity-error flag or address flag set.
- R6: With `mode_cfg[4:3]` = 3, the bit after the data is stored as the character's address flag, shown on `st_addr`. In this mode the parity-error flag is never set.
- R7: A stop bit that reads low at mid-bit sets the character's framing-error flag. The character is still stored.
- R8: If the line is high again when the start bit is rechecked half a bit after the falling edge, no character is produced.
- R9: The FIFO holds 8 characters in arrival order. `rx_avail` shows that it is not empty and `rx_full` shows that it holds 8. A `rx_pop` pulse removes the head character. A pop while the FIFO is empty has no effect.
- R10: A character that completes while the FIFO is full is discarded and sets `st_overrun`. That flag stays set until `err_reset` or `rx_reset` clears it.
- R11: With `mode_cfg[5]` = 0, `st_parity` and `st_frame` show the flags of the head character, and read 0 while the FIFO is empty.
- R12: With `mode_cfg[5]` = 1, the parity and framing flags of each received character are ORed into sticky flags shown on `st_parity` and `st_frame`. Popping characters does not clear them. Only `err_reset` or `rx_reset` does.
- R13: `rx_irq` equals `rx_avail` when `mode_cfg[6]` = 0 and equals `rx_full` when `mode_cfg[6]` = 1. `mode_cfg[7]` has no effect.
- R14: While `rx_enable` is low, the line is ignored and no character is stored. A `rx_reset` pulse empties the FIFO and clears all sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial | input | 1 | Serial receive line; high when idle |
| sample_tick | input | 1 | Sample enable, one pulse per sixteenth of a bit |
| mode_cfg | input | 8 | Mode word: length, parity type, parity mode, error mode, interrupt source |
| rx_enable | input | 1 | Receiver enable |
| rx_reset | input | 1 | Pulse: flush the FIFO, clear the flags, return to idle |
| err_reset | input | 1 | Pulse: clear the sticky parity, framing and overrun flags |
| rx_pop | input | 1 | Pulse: remove the head character |
| rx_data | output | 8 | Head character, right-aligned |
| rx_avail | output | 1 | FIFO not empty |
| rx_full | output | 1 | FIFO full |
| st_parity | output | 1 | Parity error (head or sticky, by error mode) |
| st_frame | output | 1 | Framing error (head or sticky, by error mode) |
| st_overrun | output | 1 | Sticky overrun |
| st_addr | output | 1 | Address flag of the head character |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with an oversampling ratio of 16, an FIFO depth of 8 and a two-stage input synchronizer. It drives the sample enable on every fourth clock, so one bit lasts 64 clocks. With a depth of 8, nine frames in a row are enough to reach the full condition, the interrupt on full and the overrun drop. A 64-clock bit is long enough for a start glitch of a quarter bit to be rejected cleanly. It also leaves a wide margin for the synchronizer delay at every mid-bit sample. Every parity mode, every character length and both error modes are driven through the same 8-bit mode word.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    PM_CHECK = 2'b00,
    PM_FORCE = 2'b01,
    PM_NONE  = 2'b10,
    PM_ADDR  = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic              addr;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      tick,
  input  logic      rxd_async,
  input  logic [1:0] len_code,
  input  par_mode_e par_mode,
  input  logic      par_odd,
  output logic      chr_valid,
  output rx_char_t  chr
);

  localparam int PH_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(CHAR_W);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

  // input synchronizer, idles high
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_async};
  end
  assign rxd = sync_q[SYNC_STAGES-1];

  rx_state_e         state_q, state_n;
  logic [PH_W-1:0]   phase_q, phase_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [CHAR_W-1:0] shreg_q, shreg_n;
  logic              par_q, par_n;
  logic              valid_q, valid_n;
  rx_char_t          chr_q, chr_n;

  logic [BIT_W-1:0]  last_bit;
  logic              data_par;
  logic              exp_par;
  logic              par_checked;

  assign last_bit    = BIT_W'(CHAR_W - 4) + BIT_W'(len_code);
  assign data_par    = ^shreg_q;
  assign exp_par     = (par_mode == PM_CHECK) ? (par_odd ? ~data_par : data_par) : par_odd;
  assign par_checked = (par_mode == PM_CHECK) || (par_mode == PM_FORCE);

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    bit_n   = bit_q;
    shreg_n = shreg_q;
    par_n   = par_q;
    valid_n = 1'b0;
    chr_n   = chr_q;
    if (tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!rxd) begin
            state_n = ST_START;
            phase_n = '0;
          end
        end
        ST_START: begin
          if (phase_q == PH_MID) begin
            phase_n = '0;
            if (!rxd) begin
              state_n = ST_DATA;
              bit_n   = '0;
              shreg_n = '0;
            end else begin
              state_n = ST_IDLE;
            end
          end else begin
            phase_n = phase_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (phase_q == PH_LAST) begin
            phase_n        = '0;
            shreg_n[bit_q] = rxd;
            if (bit_q == last_bit) state_n = (par_mode == PM_NONE) ? ST_STOP : ST_PAR;
            else                   bit_n   = bit_q + 1'b1;
          end else begin
            phase_n = phase_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (phase_q == PH_LAST) begin
            phase_n = '0;
            par_n   = rxd;
            state_n = ST_STOP;
          end else begin
            phase_n = phase_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (phase_q == PH_LAST) begin
            phase_n    = '0;
            state_n    = ST_IDLE;
            valid_n    = 1'b1;
            chr_n.data = shreg_q;
            chr_n.perr = par_checked & (par_q != exp_par);
            chr_n.ferr = ~rxd;
            chr_n.addr = (par_mode == PM_ADDR) & par_q;
          end else begin
            phase_n = phase_q + 1'b1;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      valid_q <= 1'b0;
      chr_q   <= '0;
    end else if (clr) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      bit_q   <= bit_n;
      shreg_q <= shreg_n;
      par_q   <= par_n;
      valid_q <= valid_n;
      chr_q   <= chr_n;
    end
  end

  assign chr_valid = valid_q;
  assign chr       = chr_q;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  rx_char_t         wdata,
  input  logic             pop,
  output rx_char_t         rdata,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             drop
);

  rx_char_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & (cnt_q != '0);
  assign drop    = push & full;

  always_comb begin
    wr_n  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_n  = do_pop  ? ptr_inc(rd_q) : rd_q;
    case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign cnt   = cnt_q;

endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic block_mode,
  input  logic chr_valid,
  input  logic chr_perr,
  input  logic chr_ferr,
  input  logic drop,
  output logic sticky_perr,
  output logic sticky_ferr,
  output logic sticky_ovr
);

  logic perr_q, perr_n;
  logic ferr_q, ferr_n;
  logic ovr_q,  ovr_n;
  logic acc;

  assign acc = block_mode & chr_valid;

  always_comb begin
    if (clr) begin
      perr_n = 1'b0;
      ferr_n = 1'b0;
      ovr_n  = 1'b0;
    end else begin
      perr_n = perr_q | (acc & chr_perr);
      ferr_n = ferr_q | (acc & chr_ferr);
      ovr_n  = ovr_q  | drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      perr_q <= perr_n;
      ferr_q <= ferr_n;
      ovr_q  <= ovr_n;
    end
  end

  assign sticky_perr = perr_q;
  assign sticky_ferr = ferr_q;
  assign sticky_ovr  = ovr_q;

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_serial,
  input  logic       sample_tick,
  input  logic [7:0] mode_cfg,
  input  logic       rx_enable,
  input  logic       rx_reset,
  input  logic       err_reset,
  input  logic       rx_pop,
  output logic [7:0] rx_data,
  output logic       rx_avail,
  output logic       rx_full,
  output logic       st_parity,
  output logic       st_frame,
  output logic       st_overrun,
  output logic       st_addr,
  output logic       rx_irq
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0]       len_code;
  logic             par_odd;
  par_mode_e        par_mode;
  logic             block_mode;
  logic             irq_on_full;
  logic             unused_mode;

  assign len_code    = mode_cfg[1:0];
  assign par_odd     = mode_cfg[2];
  assign par_mode    = par_mode_e'(mode_cfg[4:3]);
  assign block_mode  = mode_cfg[5];
  assign irq_on_full = mode_cfg[6];
  assign unused_mode = mode_cfg[7];

  logic             chr_valid;
  rx_char_t         chr_rec;
  rx_char_t         head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_drop;
  logic             sticky_perr, sticky_ferr, sticky_ovr;

  uart_rx_deframer #(
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_deframer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rx_reset | ~rx_enable),
    .tick     (sample_tick),
    .rxd_async(rx_serial),
    .len_code (len_code),
    .par_mode (par_mode),
    .par_odd  (par_odd),
    .chr_valid(chr_valid),
    .chr      (chr_rec)
  );

  uart_rx_fifo #(
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (rx_reset),
    .push (chr_valid),
    .wdata(chr_rec),
    .pop  (rx_pop),
    .rdata(head),
    .cnt  (fifo_cnt),
    .full (rx_full),
    .drop (fifo_drop)
  );

  uart_rx_errstat u_errstat (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rx_reset | err_reset),
    .block_mode (block_mode),
    .chr_valid  (chr_valid),
    .chr_perr   (chr_rec.perr),
    .chr_ferr   (chr_rec.ferr),
    .drop       (fifo_drop),
    .sticky_perr(sticky_perr),
    .sticky_ferr(sticky_ferr),
    .sticky_ovr (sticky_ovr)
  );

  assign rx_avail   = (fifo_cnt != '0);
  assign rx_data    = rx_avail ? head.data : '0;
  assign st_addr    = rx_avail & head.addr;
  assign st_parity  = block_mode ? sticky_perr : (rx_avail & head.perr);
  assign st_frame   = block_mode ? sticky_ferr : (rx_avail & head.ferr);
  assign st_overrun = sticky_ovr;
  assign rx_irq     = irq_on_full ? rx_full : rx_avail;

endmodule

// File: rtl/uart_rx_framer_chk.sv
module uart_rx_framer_chk
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enable,
  input logic             rx_reset,
  input logic             err_reset,
  input logic [1:0]       len_code,
  input par_mode_e        par_mode,
  input logic             block_mode,
  input logic             rx_avail,
  input logic             rx_full,
  input logic             st_parity,
  input logic             st_overrun,
  input logic             chr_valid,
  input logic [7:0]       chr_data,
  input logic             chr_perr,
  input logic             chr_addr,
  input logic [CNT_W-1:0] fifo_cnt
);

  // R2: one push pulse per completed frame
  p_push_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |=> !chr_valid);

  // R2: five-bit characters leave the upper bits clear
  p_len5_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && $past(len_code) == 2'b00) |-> (chr_data[7:5] == 3'b000));

  // R5: no parity bit means neither parity nor address flag
  p_none_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && $past(par_mode) == PM_NONE) |-> (!chr_perr && !chr_addr));

  // R6: multidrop never reports a parity error
  p_mdrop_noperr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && $past(par_mode) == PM_ADDR) |-> !chr_perr);

  // R9: occupancy never exceeds the depth, full implies available
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  p_full_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_avail);

  // R10: overrun holds until a clearing command
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overrun && !err_reset && !rx_reset) |=> st_overrun);

  p_errrst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_reset |=> !st_overrun);

  // R12: block-mode parity flag holds until a clearing command
  p_block_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && st_parity && !err_reset && !rx_reset) |=> (!block_mode || st_parity));

  // R14: disabled receiver produces nothing, reset flushes
  p_disable_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !chr_valid);

  p_flush_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> !rx_avail);

endmodule

bind uart_rx_framer uart_rx_framer_chk #(
  .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_enable (rx_enable),
  .rx_reset  (rx_reset),
  .err_reset (err_reset),
  .len_code  (len_code),
  .par_mode  (par_mode),
  .block_mode(block_mode),
  .rx_avail  (rx_avail),
  .rx_full   (rx_full),
  .st_parity (st_parity),
  .st_overrun(st_overrun),
  .chr_valid (chr_valid),
  .chr_data  (chr_rec.data),
  .chr_perr  (chr_rec.perr),
  .chr_addr  (chr_rec.addr),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/tb_uart_rx_framer.sv
module tb_uart_rx_framer;

  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;
  localparam int DEPTH      = 8;
  localparam int TICK_DIV   = 4;
  localparam int BIT_STEPS  = OSR * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_serial;
  logic       sample_tick;
  logic [7:0] mode_cfg;
  logic       rx_enable;
  logic       rx_reset;
  logic       err_reset;
  logic       rx_pop;
  logic [7:0] rx_data;
  logic       rx_avail, rx_full, st_parity, st_frame, st_overrun, st_addr, rx_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_framer #(
    .OVERSAMPLE (OSR),
    .FIFO_DEPTH (DEPTH),
    .SYNC_STAGES(2)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_serial  (rx_serial),
    .sample_tick(sample_tick),
    .mode_cfg   (mode_cfg),
    .rx_enable  (rx_enable),
    .rx_reset   (rx_reset),
    .err_reset  (err_reset),
    .rx_pop     (rx_pop),
    .rx_data    (rx_data),
    .rx_avail   (rx_avail),
    .rx_full    (rx_full),
    .st_parity  (st_parity),
    .st_frame   (st_frame),
    .st_overrun (st_overrun),
    .st_addr    (st_addr),
    .rx_irq     (rx_irq)
  );

  typedef struct {
    logic [7:0] data;
    logic       p;
    logic       f;
    logic       a;
  } exp_t;

  exp_t q[$];
  logic blk_p, blk_f, ovr;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   settled  = 0;
  int   tick_div = 0;

  task automatic check1(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic av, fu, hp, hf, ha;
    logic [7:0] hd;
    av = (q.size() > 0);
    fu = (q.size() == DEPTH);
    hd = av ? q[0].data : 8'h00;
    hp = av ? q[0].p : 1'b0;
    hf = av ? q[0].f : 1'b0;
    ha = av ? q[0].a : 1'b0;
    check1("R9 rx_avail", {7'd0, rx_avail}, {7'd0, av});
    check1("R9 rx_full", {7'd0, rx_full}, {7'd0, fu});
    check1("R2 rx_data", rx_data, hd);
    check1("R11 st_parity", {7'd0, st_parity}, {7'd0, mode_cfg[5] ? blk_p : hp});
    check1("R7 st_frame", {7'd0, st_frame}, {7'd0, mode_cfg[5] ? blk_f : hf});
    check1("R10 st_overrun", {7'd0, st_overrun}, {7'd0, ovr});
    check1("R6 st_addr", {7'd0, st_addr}, {7'd0, ha});
    check1("R13 rx_irq", {7'd0, rx_irq}, {7'd0, mode_cfg[6] ? fu : av});
  endtask

  task automatic step();
    @(negedge clk);
    if (settled) compare();
    tick_div    = (tick_div + 1) % TICK_DIV;
    sample_tick = (tick_div == 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic good_par(input logic [7:0] d);
    int         nb;
    logic [7:0] md;
    nb = 5 + int'(mode_cfg[1:0]);
    md = d & 8'((1 << nb) - 1);
    if (mode_cfg[4:3] == 2'b00) return mode_cfg[2] ? ~^md : ^md;
    return mode_cfg[2];
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic pbit, input logic stopb);
    int         nb;
    logic [7:0] md;
    exp_t       e;
    nb = 5 + int'(mode_cfg[1:0]);
    md = d & 8'((1 << nb) - 1);
    settled = 0;
    rx_serial = 1'b0;
    steps(BIT_STEPS);
    for (int i = 0; i < nb; i++) begin
      rx_serial = d[i];
      steps(BIT_STEPS);
    end
    if (mode_cfg[4:3] != 2'b10) begin
      rx_serial = pbit;
      steps(BIT_STEPS);
    end
    rx_serial = stopb;
    steps(BIT_STEPS);
    rx_serial = 1'b1;
    steps(stopb ? BIT_STEPS / 2 : 2 * BIT_STEPS);
    e.data = md;
    case (mode_cfg[4:3])
      2'b00:   e.p = (pbit != (mode_cfg[2] ? ~^md : ^md));
      2'b01:   e.p = (pbit != mode_cfg[2]);
      default: e.p = 1'b0;
    endcase
    e.f = ~stopb;
    e.a = (mode_cfg[4:3] == 2'b11) ? pbit : 1'b0;
    if (rx_enable) begin
      if (mode_cfg[5]) begin
        blk_p = blk_p | e.p;
        blk_f = blk_f | e.f;
      end
      if (q.size() >= DEPTH) ovr = 1'b1;
      else                   q.push_back(e);
    end
    settled = 1;
  endtask

  task automatic send_good(input logic [7:0] d);
    send_frame(d, good_par(d), 1'b1);
  endtask

  task automatic do_pop();
    rx_pop = 1'b1;
    if (q.size() > 0) void'(q.pop_front());
    step();
    rx_pop = 1'b0;
    step();
  endtask

  task automatic do_err_reset();
    err_reset = 1'b1;
    blk_p = 1'b0;
    blk_f = 1'b0;
    ovr   = 1'b0;
    step();
    err_reset = 1'b0;
    step();
  endtask

  task automatic do_rx_reset();
    rx_reset = 1'b1;
    q.delete();
    blk_p = 1'b0;
    blk_f = 1'b0;
    ovr   = 1'b0;
    step();
    rx_reset = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    rx_serial   = 1'b1;
    sample_tick = 1'b0;
    mode_cfg    = 8'h03;
    rx_enable   = 1'b1;
    rx_reset    = 1'b0;
    err_reset   = 1'b0;
    rx_pop      = 1'b0;
    blk_p       = 1'b0;
    blk_f       = 1'b0;
    ovr         = 1'b0;
    steps(6);
    rst_n = 1'b1;
    step();
    // R1: reset state
    check1("R1 rx_avail", {7'd0, rx_avail}, 8'h00);
    check1("R1 rx_irq", {7'd0, rx_irq}, 8'h00);
    check1("R1 flags", {4'd0, st_parity, st_frame, st_overrun, st_addr}, 8'h00);
    check1("R1 rx_data", rx_data, 8'h00);
    settled = 1;
    steps(20);

    // R2: every character length, even parity
    mode_cfg = 8'h03; send_good(8'hA5);
    check1("R2 len8 data", rx_data, 8'hA5);
    do_pop();
    mode_cfg = 8'h00; send_good(8'hF5);
    check1("R2 len5 data", rx_data, 8'h15);
    do_pop();
    mode_cfg = 8'h01; send_good(8'hEA);
    check1("R2 len6 data", rx_data, 8'h2A);
    do_pop();
    mode_cfg = 8'h02; send_good(8'hD5);
    check1("R2 len7 data", rx_data, 8'h55);
    do_pop();

    // R3: checked parity, even then odd, good and bad
    mode_cfg = 8'h03; send_frame(8'h3C, ~good_par(8'h3C), 1'b1);
    check1("R3 even bad", {7'd0, st_parity}, 8'h01);
    do_pop();
    mode_cfg = 8'h07; send_good(8'h3C);
    check1("R3 odd good", {7'd0, st_parity}, 8'h00);
    do_pop();
    send_frame(8'h71, ~good_par(8'h71), 1'b1);
    check1("R3 odd bad", {7'd0, st_parity}, 8'h01);
    do_pop();

    // R4: forced parity level
    mode_cfg = 8'h0B; send_frame(8'h5A, 1'b0, 1'b1);
    check1("R4 force0 ok", {7'd0, st_parity}, 8'h00);
    do_pop();
    send_frame(8'h5A, 1'b1, 1'b1);
    check1("R4 force0 bad", {7'd0, st_parity}, 8'h01);
    do_pop();
    mode_cfg = 8'h0F; send_frame(8'h5A, 1'b0, 1'b1);
    check1("R4 force1 bad", {7'd0, st_parity}, 8'h01);
    do_pop();

    // R5: no parity bit
    mode_cfg = 8'h13; send_frame(8'h81, 1'b0, 1'b1);
    check1("R5 none data", rx_data, 8'h81);
    check1("R5 none flags", {6'd0, st_parity, st_addr}, 8'h00);
    do_pop();

    // R6: multidrop address flag
    mode_cfg = 8'h1B; send_frame(8'h42, 1'b1, 1'b1);
    check1("R6 addr set", {6'd0, st_addr, st_parity}, 8'h02);
    do_pop();
    send_frame(8'h43, 1'b0, 1'b1);
    check1("R6 addr clear", {6'd0, st_addr, st_parity}, 8'h00);
    do_pop();

    // R7: low stop bit
    mode_cfg = 8'h03; send_frame(8'h99, good_par(8'h99), 1'b0);
    check1("R7 frame err", {7'd0, st_frame}, 8'h01);
    do_pop();

    // R8: start glitch shorter than half a bit
    settled = 0;
    rx_serial = 1'b0; steps(BIT_STEPS / 4);
    rx_serial = 1'b1; steps(3 * BIT_STEPS);
    settled = 1; step();
    check1("R8 glitch ignored", {7'd0, rx_avail}, 8'h00);

    // R9 R10 R13: fill, interrupt on full, overrun
    mode_cfg = 8'h43;
    for (int k = 0; k < DEPTH; k++) send_good(8'(8'h10 + k));
    check1("R13 irq on full", {7'd0, rx_irq}, 8'h01);
    send_good(8'hEE);
    check1("R10 overrun", {7'd0, st_overrun}, 8'h01);
    check1("R10 head kept", rx_data, 8'h10);
    mode_cfg = 8'h03;
    for (int k = 0; k < DEPTH; k++) do_pop();
    do_pop();
    check1("R9 empty pop", {7'd0, rx_avail}, 8'h00);
    check1("R10 overrun held", {7'd0, st_overrun}, 8'h01);
    do_err_reset();

    // R12: sticky block flags
    mode_cfg = 8'h23; send_frame(8'h0F, ~good_par(8'h0F), 1'b1);
    send_good(8'h33);
    do_pop(); do_pop();
    check1("R12 sticky after pops", {7'd0, st_parity}, 8'h01);
    do_err_reset();
    check1("R12 cleared", {7'd0, st_parity}, 8'h00);

    // R14: disable, then flush
    mode_cfg = 8'h03;
    rx_enable = 1'b0; step();
    send_good(8'h77);
    check1("R14 disabled", {7'd0, rx_avail}, 8'h00);
    rx_enable = 1'b1; steps(4);
    send_good(8'h12);
    send_frame(8'h34, 1'b0, 1'b0);
    do_rx_reset();
    check1("R14 flushed", {6'd0, rx_avail, st_frame}, 8'h00);
    steps(20);

    settled = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule